// File: doc/BRIEF.md
# Two-Dimensional DMA Word Address Generator

This block produces the word address stream for one DMA channel. Software gives a start word address and a geometry, then pulses a start strobe. The generator then issues one word-address beat at a time toward the memory side and advances only when that side accepts a beat. Every beat is 32 bits wide, so every address counts 4-byte words. A byte address maps to a word address by shifting it right by two.

Two modes are selected by the x length. A nonzero x length gives a rectangular walk over `y_len + 1` lines of `x_len` words each. Line starts are spaced by a stride of `width` words, which covers the line plus the gap after it. A zero x length gives a circular sweep over `width * (y_len + 1)` words. That region is split into two halves. A pulse marks the end of each half on every pass, and the sweep runs until it is aborted. The transfer direction given at start is carried beside the addresses unchanged.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `beat_valid_o`, `busy_o`, `done_o`, `half_o` and `full_o` are all 0.
- R2: A start pulse while idle (and without abort) makes `beat_valid_o` and `busy_o` 1 on the next cycle. A beat is accepted in a cycle where `beat_valid_o` and `beat_ready_i` are both 1. While ready is 0 the address holds.
- R3: The first beat carries the start address, and accepted beats within a line advance the address by exactly one word.
- R4: In rectangle mode (x length nonzero), the beat after the last word of a line is at that line's start plus `width`. Exactly `(y_len + 1) * x_len` beats are issued.
- R5: In rectangle mode, `done_o` is a one-cycle pulse in the cycle after the final beat is accepted. In that cycle `beat_valid_o` and `busy_o` are already 0.
- R6: In circular mode (x length 0, `width` nonzero), the region is L = `width * (y_len + 1)` words from the start address. After the beat at offset L-1 the next address is the start address again. `half_o` pulses in the cycle after offset floor(L/2)-1 is accepted. `full_o` pulses in the cycle after offset L-1 is accepted. `done_o` never pulses in this mode.
- R7: `dir_o` shows the direction value captured at start (1 = memory to device, 0 = device to memory) and stays constant while busy.
- R8: When `abort_i` is 1, the next cycle has `busy_o`, `beat_valid_o`, `done_o`, `half_o` and `full_o` all 0, even if a beat was accepted in the abort cycle.
- R9: A start pulse while busy is ignored: the geometry, address and direction in use are not changed.
- R10: Start and abort in the same idle cycle leave the generator idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| abort_i | input | 1 | Stop and return to idle |
| base_i | input | AW | Start word address |
| xlen_i | input | XW | Words per line; 0 selects circular mode |
| width_i | input | WW | Line stride in words (region scale in circular mode) |
| ylen_i | input | YW | Number of lines minus one |
| dir_i | input | 1 | Direction captured at start |
| beat_ready_i | input | 1 | Memory side accepts the current beat |
| beat_valid_o | output | 1 | A beat address is offered |
| beat_addr_o | output | AW | Word address of the offered beat |
| dir_o | output | 1 | Captured direction |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | Rectangle transfer finished (pulse) |
| half_o | output | 1 | Circular mode: first half reached (pulse) |
| full_o | output | 1 | Circular mode: region end reached, wrapping (pulse) |

## Verification
Directed rectangles with a stride larger than the line length separate a correct jump to the next line start from a plain increment. A single-word, single-line job exposes any off-by-one in the x and y end tests. A small circular region swept twice shows whether the wrap goes back to the start address and whether both half events recur on every pass. An abort placed on the wrapping beat checks that the event from that beat is suppressed. Random jobs with random ready gaps, mixed modes and stray start pulses while busy are then compared cycle by cycle against a reference model. These show whether back-pressure, ignored restarts and the direction flag all behave as required.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/dma2d_line_walk.sv
// Rectangle walk: tracks position inside the line and line count,
// and offers the next address for the currently shown beat.
module dma2d_line_walk #(
  parameter int AW = 30,
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [XW-1:0] xlen_i,
  input  logic [YW-1:0] ylen_i,
  input  logic [WW-1:0] width_i,
  input  logic [AW-1:0] cur_i,
  output logic [AW-1:0] nxt_o,
  output logic          last_o
);
  logic [XW-1:0] xcnt_q, xlast_q;
  logic [YW-1:0] ycnt_q, ylast_q;
  logic [WW-1:0] width_q;
  logic [AW-1:0] lstart_q;
  logic          eol;

  assign eol    = (xcnt_q == xlast_q);
  assign last_o = eol && (ycnt_q == ylast_q);
  assign nxt_o  = eol ? (lstart_q + AW'(width_q)) : (cur_i + AW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      xcnt_q   <= '0;
      xlast_q  <= '0;
      ycnt_q   <= '0;
      ylast_q  <= '0;
      width_q  <= '0;
      lstart_q <= '0;
    end else if (load_i) begin
      xcnt_q   <= '0;
      xlast_q  <= xlen_i - XW'(1);
      ycnt_q   <= '0;
      ylast_q  <= ylen_i;
      width_q  <= width_i;
      lstart_q <= base_i;
    end else if (step_i) begin
      if (eol) begin
        xcnt_q   <= '0;
        ycnt_q   <= ycnt_q + YW'(1);
        lstart_q <= lstart_q + AW'(width_q);
      end else begin
        xcnt_q <= xcnt_q + XW'(1);
      end
    end
  end

  // R4: a stepped beat never lies beyond the last line
  p_line_bound_r4: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (ycnt_q <= ylast_q));

  // R4: at the end of a line the next beat opens the following line
  p_line_jump_r4: assert property (@(posedge clk) disable iff (rst)
    step_i && eol && !last_o |=> (xcnt_q == '0));
endmodule

// File: rtl/dma2d_loop_walk.sv
// Circular sweep: offset inside the region, half and end detection.
module dma2d_loop_walk #(
  parameter int AW = 30,
  parameter int YW = 16,
  parameter int WW = 16,
  parameter int LW = WW + YW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [YW-1:0] ylen_i,
  input  logic [WW-1:0] width_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] cur_i,
  output logic [AW-1:0] nxt_o,
  output logic          half_o,
  output logic          end_o
);
  logic [LW-1:0] len_q, off_q, half_len;

  assign half_len = len_q >> 1;
  assign half_o   = (off_q == half_len - LW'(1));
  assign end_o    = (off_q == len_q - LW'(1));
  assign nxt_o    = end_o ? base_i : (cur_i + AW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      off_q <= '0;
    end else if (load_i) begin
      len_q <= LW'(width_i) * (LW'(ylen_i) + LW'(1));
      off_q <= '0;
    end else if (step_i) begin
      off_q <= end_o ? '0 : (off_q + LW'(1));
    end
  end

  // R6: the offset stays inside the region on every accepted beat
  p_off_region_r6: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (off_q < len_q));

  // R6: after the region end the sweep restarts at offset zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    step_i && end_o |=> (off_q == '0));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] base_i,
  input  logic [XW-1:0] xlen_i,
  input  logic [WW-1:0] width_i,
  input  logic [YW-1:0] ylen_i,
  input  logic          dir_i,
  input  logic          beat_ready_i,
  output logic          beat_valid_o,
  output logic [AW-1:0] beat_addr_o,
  output logic          dir_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          half_o,
  output logic          full_o
);
  localparam int LW = WW + YW;

  gen_state_e    state_q;
  logic [AW-1:0] addr_q, base_q;
  logic          valid_q, loop_q, dir_q;
  logic          done_q, half_q, full_q;

  logic          launch, step;
  logic [AW-1:0] ln_nxt, lp_nxt;
  logic          ln_last, lp_half, lp_end;

  assign launch = (state_q == ST_IDLE) && start_i && !abort_i;
  assign step   = (state_q == ST_RUN) && valid_q && beat_ready_i && !abort_i;

  dma2d_line_walk #(.AW(AW), .XW(XW), .YW(YW), .WW(WW)) u_line (
    .clk     (clk),
    .rst     (rst),
    .load_i  (launch),
    .step_i  (step && !loop_q),
    .base_i  (base_i),
    .xlen_i  (xlen_i),
    .ylen_i  (ylen_i),
    .width_i (width_i),
    .cur_i   (addr_q),
    .nxt_o   (ln_nxt),
    .last_o  (ln_last)
  );

  dma2d_loop_walk #(.AW(AW), .YW(YW), .WW(WW), .LW(LW)) u_loop (
    .clk     (clk),
    .rst     (rst),
    .load_i  (launch),
    .step_i  (step && loop_q),
    .ylen_i  (ylen_i),
    .width_i (width_i),
    .base_i  (base_q),
    .cur_i   (addr_q),
    .nxt_o   (lp_nxt),
    .half_o  (lp_half),
    .end_o   (lp_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      loop_q  <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      half_q <= 1'b0;
      full_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        valid_q <= 1'b0;
      end else if (launch) begin
        state_q <= ST_RUN;
        valid_q <= 1'b1;
        addr_q  <= base_i;
        base_q  <= base_i;
        loop_q  <= (xlen_i == '0);
        dir_q   <= dir_i;
      end else if (step) begin
        if (loop_q) begin
          addr_q <= lp_nxt;
          half_q <= lp_half;
          full_q <= lp_end;
        end else if (ln_last) begin
          state_q <= ST_IDLE;
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          addr_q <= ln_nxt;
        end
      end
    end
  end

  assign beat_valid_o = valid_q;
  assign beat_addr_o  = addr_q;
  assign dir_o        = dir_q;
  assign busy_o       = (state_q == ST_RUN);
  assign done_o       = done_q;
  assign half_o       = half_q;
  assign full_o       = full_q;

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    launch |=> beat_valid_o && busy_o && (beat_addr_o == $past(base_i)));

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (rst)
    beat_valid_o && !beat_ready_i && !abort_i |=> beat_valid_o && $stable(beat_addr_o));

  p_done_end_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !beat_valid_o && !busy_o);

  p_events_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, half_o, full_o}));

  p_dir_stable_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(dir_o));

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !busy_o && !beat_valid_o && !done_o && !half_o && !full_o);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o && !step && !abort_i |=> $stable(beat_addr_o) && $stable(dir_o));
endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  localparam int AW = 30;
  localparam int XW = 16;
  localparam int YW = 16;
  localparam int WW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, abort = 1'b0, dir = 1'b0, ready = 1'b0;
  logic [AW-1:0] base = '0;
  logic [XW-1:0] xlen = '0;
  logic [YW-1:0] ylen = '0;
  logic [WW-1:0] width = '0;
  logic          valid_w, dir_w, busy_w, done_w, half_w, full_w;
  logic [AW-1:0] addr_w;

  dma2d_addr_gen #(.AW(AW), .XW(XW), .YW(YW), .WW(WW)) uut (
    .clk (clk), .rst (rst), .start_i (start), .abort_i (abort),
    .base_i (base), .xlen_i (xlen), .width_i (width), .ylen_i (ylen),
    .dir_i (dir), .beat_ready_i (ready),
    .beat_valid_o (valid_w), .beat_addr_o (addr_w), .dir_o (dir_w),
    .busy_o (busy_w), .done_o (done_w), .half_o (half_w), .full_o (full_w)
  );

  always #4 clk = ~clk;

  int unsigned n_vec = 0, n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // reference model, built from the requirements
  longint m_addr, m_base, m_ls, m_x, m_y, m_xl, m_yl, m_w, m_off, m_len;
  bit m_busy, m_valid, m_loop, m_dir, m_done, m_half, m_full;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_valid = 0; m_done = 0; m_half = 0; m_full = 0;
      m_dir = 0; m_addr = 0;
    end else begin
      m_done = 0; m_half = 0; m_full = 0;
      if (abort) begin
        m_busy = 0; m_valid = 0;
      end else if (!m_busy && start) begin
        m_busy = 1; m_valid = 1; m_base = base; m_addr = base; m_ls = base;
        m_x = 0; m_y = 0; m_xl = xlen; m_yl = ylen; m_w = width; m_off = 0;
        m_loop = (xlen == 0); m_dir = dir; m_len = longint'(width) * (longint'(ylen) + 1);
      end else if (m_busy && m_valid && ready) begin
        if (m_loop) begin
          if (m_off == m_len / 2 - 1) m_half = 1;
          if (m_off == m_len - 1) begin
            m_full = 1; m_off = 0; m_addr = m_base;
          end else begin
            m_off++; m_addr++;
          end
        end else if (m_x == m_xl - 1) begin
          if (m_y == m_yl) begin
            m_done = 1; m_valid = 0; m_busy = 0;
          end else begin
            m_ls = m_ls + m_w; m_addr = m_ls; m_x = 0; m_y++;
          end
        end else begin
          m_x++; m_addr++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 beat valid", valid_w, m_valid);
      if (m_valid) chk("R3 beat address", addr_w, m_addr);
      if (m_busy) chk("R7 direction", dir_w, m_dir);
      chk("R1 busy", busy_w, m_busy);
      chk("R5 done", done_w, m_done);
      chk("R6 half event", half_w, m_half);
      chk("R6 full event", full_w, m_full);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  task automatic cfg(input longint b, input longint x, input longint w, input longint y, input bit d);
    base = AW'(b); xlen = XW'(x); width = WW'(w); ylen = YW'(y); dir = d;
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 valid after reset", valid_w, 0);
    chk("R1 busy after reset", busy_w, 0);
    chk("R1 events after reset", {done_w, half_w, full_w}, 0);
    cmp_en = 1'b1;

    // rectangle with stride larger than the line (R3 R4 R5)
    cfg(100, 3, 8, 1, 1); ready = 1; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 6; i++) begin
      chk("R4 stride address", addr_w, 100 + (i / 3) * 8 + (i % 3));
      chk("R3 beat offered", valid_w, 1);
      @(negedge clk);
    end
    chk("R5 done pulse", done_w, 1);
    chk("R5 valid low at done", valid_w, 0);
    @(negedge clk);
    chk("R5 done one cycle", done_w, 0);

    // circular sweep L=4, then abort on the wrapping beat (R6 R8)
    cfg(200, 0, 2, 1, 0); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 10; i++) begin
      chk("R6 wrap address", addr_w, 200 + (i % 4));
      chk("R6 half position", half_w, (i > 0 && i % 4 == 2));
      chk("R6 full position", full_w, (i > 0 && i % 4 == 0));
      @(negedge clk);
    end
    @(negedge clk);
    chk("R6 address before abort", addr_w, 203);
    abort = 1;
    @(negedge clk); abort = 0;
    chk("R8 busy after abort", busy_w, 0);
    chk("R8 valid after abort", valid_w, 0);
    chk("R8 full suppressed", full_w, 0);

    // restart while busy is ignored, back-pressure holds (R9 R2 R7)
    ready = 0; cfg(500, 4, 4, 0, 0); start = 1;
    @(negedge clk); start = 0;
    cfg(900, 2, 2, 2, 1); start = 1;
    @(negedge clk); start = 0;
    chk("R9 address kept", addr_w, 500);
    chk("R7 direction kept", dir_w, 0);
    @(negedge clk);
    chk("R2 held without ready", addr_w, 500);
    ready = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R9 original line", addr_w, 500 + i);
      @(negedge clk);
    end
    chk("R9 original length", done_w, 1);

    // start and abort together while idle (R10)
    start = 1; abort = 1;
    @(negedge clk); start = 0; abort = 0;
    chk("R10 stays idle", busy_w, 0);
    @(negedge clk);
    chk("R10 no beat", valid_w, 0);

    // single word, single line (R4 R5)
    cfg(7, 1, 1, 0, 1); start = 1;
    @(negedge clk); start = 0;
    chk("R4 single beat address", addr_w, 7);
    @(negedge clk);
    chk("R5 done after single beat", done_w, 1);

    // random jobs
    for (int j = 0; j < 60; j++) begin
      longint x, w;
      x = $urandom_range(0, 5);
      w = x + $urandom_range(0, 4);
      if (w == 0) w = 1;
      cfg($urandom_range(0, 1 << 20), x, w, $urandom_range(0, 3), $urandom_range(0, 1));
      start = 1;
      @(negedge clk); start = 0;
      for (int c = 0; c < 200; c++) begin
        ready = ($urandom % 10) < 7;
        start = m_busy && ($urandom % 25 == 0);
        abort = (x == 0 && c == 40) || ($urandom % 200 == 0);
        @(negedge clk);
        start = 0; abort = 0;
        if (!m_busy) break;
      end
      ready = 0;
      @(negedge clk);
    end
    wrap_up();
  end
endmodule